// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block places stereo sample words on one serial data line in response to a bit clock and a word clock that another device supplies. Both clocks are oversampled by a faster system clock. The block keeps count of bit periods within a 64-period frame, which holds two 32-period channel slots. On each falling bit-clock edge it drives the bit that belongs to the period that is starting.

There are four framing formats. The two left-aligned formats differ only in a one-period delay of the MSB and in the word-clock level that marks the left channel. The right-aligned format ends each word on the last period of its slot. The pulse format uses a one-period frame-sync pulse in place of a level word clock. The word width can be set to 16, 20 or 24 bits. Both channel words are captured together when a frame starts, so the host may update them at any time.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, and after its release until the transmitter has aligned to the word clock, `sdata_out` is 0.
- R2: The word clock is sampled on rising bit-clock edges. `sdata_out` changes only after a falling bit-clock edge and holds steady through the high phase that follows.
- R3: Format code 0 (two-wire standard): word clock low marks the left slot and high marks the right slot. The MSB goes out in period 1 of each slot, and period 0 carries 0.
- R4: Format code 1 (left-aligned): word clock high marks the left slot and low marks the right slot. The MSB goes out in period 0 of each slot.
- R5: Format code 2 (right-aligned): channel polarity is the same as in R4. The LSB goes out in period 31 of each slot, so the MSB falls in period 32 minus the width.
- R6: Format code 3 (pulse sync): a word-clock high lasting one period marks the last period of a frame. The left MSB goes out in the next period, and the right MSB goes out 32 periods after the left MSB.
- R7: Width code 0 selects 16 bits, code 1 selects 20, and codes 2 and 3 select 24. A sample is taken from bits [width-1:0] of its input word, and higher input bits are ignored.
- R8: Every period that does not carry a data bit drives 0.
- R9: Both input words are captured at the falling edge that begins period 0 of the left slot. A change to the inputs during a frame shows up only from the next frame on.
- R10: Once the first word-clock boundary has been seen, the output stays 0 until the next frame start. From that frame on, data is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Bit clock from the external timing source |
| wclk_in | input | 1 | Word clock, or the frame-sync pulse in format 3 |
| fmt_sel | input | 2 | Framing format code (0 to 3) |
| wlen_sel | input | 2 | Word width code |
| left_word | input | 24 | Left sample, right-aligned in the word |
| right_word | input | 24 | Right sample, right-aligned in the word |
| sdata_out | output | 1 | Serial data, updated after falling bit-clock edges |

## Verification
The assertions rely on the system clock running at least about eight times faster than the bit clock, so that each bit-clock edge is seen as its own event and the data update lands within the bit period. They also rely on the format and width codes staying constant for a whole frame, and on every frame being exactly 64 bit periods long. The stimulus uses a bit clock of 16 system cycles and changes the word clock only on falling edges. It changes the format only at a frame boundary, and each new setting is followed by a discarded frame before any output is compared.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_PULSE = 2'd3
  } fmt_e;

  localparam int unsigned WLEN_SHORT = 16;
  localparam int unsigned WLEN_MID   = 20;
  localparam int unsigned WLEN_LONG  = 24;

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= raw_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/aud_slot_track.sv
module aud_slot_track
  import aud_ser_pkg::*;
#(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_en,
  input  logic             wclk_lvl,
  input  fmt_e             fmt,
  output logic [POS_W-1:0] pos,
  output logic             locked
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             primed_q, primed_d;
  logic             locked_q, locked_d;
  logic             wprev_q, wprev_d;
  logic             chan;

  // channel selected by the level seen at a slot boundary
  assign chan = (fmt == FMT_STD) ? wclk_lvl : ~wclk_lvl;

  always_comb begin
    pos_d    = pos_q;
    primed_d = primed_q;
    locked_d = locked_q;
    wprev_d  = wprev_q;
    if (rise_en) begin
      wprev_d  = wclk_lvl;
      primed_d = 1'b1;
      pos_d    = pos_q + 1'b1;
      if (primed_q) begin
        if (fmt == FMT_PULSE) begin
          if (wclk_lvl && !wprev_q) begin
            pos_d    = '1;
            locked_d = 1'b1;
          end
        end else if (wclk_lvl != wprev_q) begin
          pos_d    = {chan, {(POS_W-1){1'b0}}};
          locked_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      primed_q <= 1'b0;
      locked_q <= 1'b0;
      wprev_q  <= 1'b0;
    end else begin
      pos_q    <= pos_d;
      primed_q <= primed_d;
      locked_q <= locked_d;
      wprev_q  <= wprev_d;
    end
  end

  assign pos    = pos_q;
  assign locked = locked_q;

endmodule

// File: rtl/aud_word_out.sv
module aud_word_out
  import aud_ser_pkg::*;
#(
  parameter int unsigned WORD_MAX  = 24,
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned POS_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_en,
  input  logic                locked,
  input  logic [POS_W-1:0]    pos,
  input  fmt_e                fmt,
  input  logic [1:0]          wlen,
  input  logic [WORD_MAX-1:0] left_in,
  input  logic [WORD_MAX-1:0] right_in,
  output logic                sdata
);

  localparam int unsigned IDX_W = $clog2(SLOT_BITS);
  localparam logic [IDX_W:0] SLOT_C = SLOT_BITS[IDX_W:0];

  logic [POS_W-1:0]    next_pos;
  logic [IDX_W:0]      bpos, width, idx;
  logic                chan, start, hit, bit_v, live_d;
  logic [WORD_MAX-1:0] word, shifted;
  logic [WORD_MAX-1:0] left_q, right_q;
  logic                live_q, sd_q, sd_d;

  assign next_pos = pos + 1'b1;
  assign bpos     = {1'b0, next_pos[IDX_W-1:0]};
  assign chan     = next_pos[POS_W-1];
  assign start    = (next_pos == '0);

  always_comb begin
    unique case (wlen)
      2'd0:    width = (IDX_W+1)'(WLEN_SHORT);
      2'd1:    width = (IDX_W+1)'(WLEN_MID);
      default: width = (IDX_W+1)'(WLEN_LONG);
    endcase
  end

  // bit placement per framing format
  always_comb begin
    hit = 1'b0;
    idx = '0;
    unique case (fmt)
      FMT_STD: begin
        hit = (bpos >= (IDX_W+1)'(1)) && (bpos <= width);
        idx = width - bpos;
      end
      FMT_RIGHT: begin
        hit = (bpos >= (SLOT_C - width));
        idx = SLOT_C - (IDX_W+1)'(1) - bpos;
      end
      default: begin
        hit = (bpos < width);
        idx = width - (IDX_W+1)'(1) - bpos;
      end
    endcase
  end

  assign word    = start ? left_in : (chan ? right_q : left_q);
  assign shifted = word >> idx;
  assign bit_v   = shifted[0];
  assign live_d  = live_q | (locked & start);
  assign sd_d    = live_d & hit & bit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      live_q  <= 1'b0;
      sd_q    <= 1'b0;
    end else if (fall_en) begin
      if (locked && start) begin
        left_q  <= left_in;
        right_q <= right_in;
      end
      live_q <= live_d;
      sd_q   <= sd_d;
    end
  end

  assign sdata = sd_q;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int unsigned WORD_MAX    = 24,
  parameter int unsigned SLOT_BITS   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                wclk_in,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic [WORD_MAX-1:0] left_word,
  input  logic [WORD_MAX-1:0] right_word,
  output logic                sdata_out
);

  localparam int unsigned POS_W = $clog2(SLOT_BITS) + 1;

  logic [1:0]       sync_v;
  logic             bclk_s, wclk_s;
  logic             bclk_prev_q;
  logic             bclk_rise, bclk_fall;
  logic [POS_W-1:0] slot_pos;
  logic             locked;
  fmt_e             fmt;

  assign fmt = fmt_e'(fmt_sel);

  aud_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_in  ({bclk_in, wclk_in}),
    .sync_out(sync_v)
  );

  assign bclk_s = sync_v[1];
  assign wclk_s = sync_v[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_s;
  end

  assign bclk_rise = bclk_s & ~bclk_prev_q;
  assign bclk_fall = ~bclk_s & bclk_prev_q;

  aud_slot_track #(.POS_W(POS_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_en (bclk_rise),
    .wclk_lvl(wclk_s),
    .fmt     (fmt),
    .pos     (slot_pos),
    .locked  (locked)
  );

  aud_word_out #(
    .WORD_MAX (WORD_MAX),
    .SLOT_BITS(SLOT_BITS),
    .POS_W    (POS_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_en (bclk_fall),
    .locked  (locked),
    .pos     (slot_pos),
    .fmt     (fmt),
    .wlen    (wlen_sel),
    .left_in (left_word),
    .right_in(right_word),
    .sdata   (sdata_out)
  );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk
  import aud_ser_pkg::*;
#(
  parameter int unsigned WORD_MAX  = 24,
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned POS_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       fmt_sel,
  input logic             sdata_out,
  input logic             bclk_rise,
  input logic             bclk_fall,
  input logic [POS_W-1:0] slot_pos,
  input logic             locked
);

  localparam int unsigned IDX_W = $clog2(SLOT_BITS);

  logic [POS_W-1:0] nxt;
  logic [IDX_W-1:0] nb;
  assign nxt = slot_pos + 1'b1;
  assign nb  = nxt[IDX_W-1:0];

  p_quiet_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sdata_out);

  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_out) |-> $past(bclk_fall));

  p_pos_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bclk_rise) |-> $stable(slot_pos));

  p_std_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && fmt_sel == FMT_STD && nb == '0) |=> !sdata_out);

  p_right_lead_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && fmt_sel == FMT_RIGHT &&
     32'(nb) < (SLOT_BITS - WORD_MAX)) |=> !sdata_out);

  p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && (fmt_sel == FMT_LEFT || fmt_sel == FMT_PULSE) &&
     32'(nb) >= WORD_MAX) |=> !sdata_out);

endmodule

bind aud_ser_tx aud_ser_tx_chk #(
  .WORD_MAX (WORD_MAX),
  .SLOT_BITS(SLOT_BITS),
  .POS_W    (POS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fmt_sel  (fmt_sel),
  .sdata_out(sdata_out),
  .bclk_rise(bclk_rise),
  .bclk_fall(bclk_fall),
  .slot_pos (slot_pos),
  .locked   (locked)
);

// File: tb/sim_aud_ser_tx.sv
module sim_aud_ser_tx;
  import aud_ser_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, wclk;
  logic [1:0]  fmt, wl;
  logic [23:0] lw, rw;
  logic        sd;
  int          n_run = 0;
  int          n_fail = 0;
  int          unstable_total = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  aud_ser_tx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .wclk_in(wclk),
    .fmt_sel(fmt), .wlen_sel(wl), .left_word(lw), .right_word(rw),
    .sdata_out(sd)
  );

  // {format, width code, left, right}
  localparam logic [51:0] VEC [10] = '{
    {2'd0, 2'd0, 24'hFFA5C3, 24'h123C5A},
    {2'd0, 2'd2, 24'hC00001, 24'h800003},
    {2'd1, 2'd1, 24'hF81234, 24'h0ABCDE},
    {2'd1, 2'd2, 24'h9ACE01, 24'h5A5A5A},
    {2'd2, 2'd0, 24'h77F00F, 24'h00C001},
    {2'd2, 2'd2, 24'hC30081, 24'h800001},
    {2'd2, 2'd1, 24'hFAAAAA, 24'h055555},
    {2'd3, 2'd0, 24'h00B00D, 24'hFF8001},
    {2'd3, 2'd2, 24'hE4E4E5, 24'h1B1B1B},
    {2'd1, 2'd3, 24'h800000, 24'hC0FFEE}
  };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_of(input logic [1:0] f, input int w,
                                          input logic [23:0] x);
    logic [31:0] m = (32'h1 << w) - 32'h1;
    logic [31:0] v = {8'h0, x} & m;
    if (f == 2'd0)      return v << (31 - w);
    else if (f == 2'd2) return v;
    else                return v << (32 - w);
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] f, input logic [1:0] c,
                                            input logic [23:0] l, input logic [23:0] r);
    int w = (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
    return {slot_of(f, w, l), slot_of(f, w, r)};
  endfunction

  function automatic logic wlevel(input logic [1:0] f, input int p);
    if (f == 2'd0)      return (p >= 32);
    else if (f == 2'd3) return (p == 63);
    else                return (p < 32);
  endfunction

  task automatic run_frame(input logic [1:0] f, input logic [1:0] c,
                           input logic [23:0] l, input logic [23:0] r,
                           input int chg_at, input logic [23:0] l2, input logic [23:0] r2,
                           output logic [63:0] got);
    logic s1, s2;
    fmt = f; wl = c; lw = l; rw = r;
    for (int p = 0; p < 64; p++) begin
      bclk = 1'b0;
      wclk = wlevel(f, p);
      if (p == chg_at) begin lw = l2; rw = r2; end
      repeat (8) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
      s1 = sd;
      repeat (4) @(negedge clk);
      s2 = sd;
      got[63-p] = s2;
      if (s1 !== s2) unstable_total++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, exp;
    rst_n = 1'b0; bclk = 1'b0; wclk = 1'b1;
    fmt = 2'd0; wl = 2'd2; lw = '0; rw = '0;
    repeat (5) @(negedge clk);
    check(sd === 1'b0, "R1 in reset", {63'd0, sd}, 64'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(sd === 1'b0, "R1 after release", {63'd0, sd}, 64'd0);

    // R10: first frame after alignment stays silent
    run_frame(2'd0, 2'd2, 24'hFFFFFF, 24'hFFFFFF, -1, 24'h0, 24'h0, got);
    check(got == 64'd0, "R10 first frame", got, 64'd0);

    // vector table: a settling frame, then a compared frame
    for (int i = 0; i < 10; i++) begin
      logic [1:0] vf, vc;
      logic [23:0] vl, vr;
      string tag;
      {vf, vc, vl, vr} = VEC[i];
      tag = (vf == 2'd0) ? "R3 R7 R8" : (vf == 2'd1) ? "R4 R7 R8" :
            (vf == 2'd2) ? "R5 R7 R8" : "R6 R7 R8";
      run_frame(vf, vc, vl, vr, -1, 24'h0, 24'h0, got);
      run_frame(vf, vc, vl, vr, -1, 24'h0, 24'h0, got);
      exp = exp_frame(vf, vc, vl, vr);
      check(got == exp, tag, got, exp);
    end

    // R9: mid-frame changes affect only the following frame
    run_frame(2'd1, 2'd2, 24'h123456, 24'h654321, -1, 24'h0, 24'h0, got);
    run_frame(2'd1, 2'd2, 24'hA1B2C3, 24'h3C2B1A, 5, 24'h0F0F0F, 24'hF0F0F0, got);
    exp = exp_frame(2'd1, 2'd2, 24'hA1B2C3, 24'h3C2B1A);
    check(got == exp, "R9 old words kept", got, exp);
    run_frame(2'd1, 2'd2, 24'h0F0F0F, 24'hF0F0F0, 40, 24'hFFFFFF, 24'hFFFFFF, got);
    exp = exp_frame(2'd1, 2'd2, 24'h0F0F0F, 24'hF0F0F0);
    check(got == exp, "R9 new words next frame", got, exp);

    check(unstable_total == 0, "R2 steady in high phase",
          64'(unstable_total), 64'd0);

    // R1: reset in mid-stream forces the line low
    bclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sd === 1'b0, "R1 reset mid-stream", {63'd0, sd}, 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule